// File: doc/BRIEF.md
# Magnitude Moving Averager

This block turns a wide signed sample stream into a slowly varying level estimate. Each accepted sample is reduced to its absolute value. That value is shifted right by a fixed amount, clipped to a narrow unsigned word, and added to a window holding the most recent scaled values. The block reports the window mean. A typical use is to follow the output of a filter and tell whether a test tone passes the filter (the level stays large) or is rejected by it (the level stays small).

The window lives in an inferred memory that is addressed as a ring. Each accepted sample reads out the value leaving the window and writes the new value into the same slot. A running sum adds the newcomer and removes the leaver, so every update costs one addition and one subtraction, whatever the window depth. After reset the window counts as empty (all zeros), so the mean ramps up over the first window's worth of samples.

Top module: `mag_avg_top`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, `avg_valid` is 0 and `avg_out` is 0 after that edge.
- R2: A sample accepted at rising edge k (`in_valid` high) makes `avg_valid` high for exactly the one cycle that follows edge k+2. Each accepted sample gives exactly one such pulse.
- R3: Cycles with `in_valid` low change nothing: they produce no `avg_valid` pulse, and `avg_out` holds its value whenever `avg_valid` is low.
- R4: The magnitude of a sample is its two's-complement absolute value. This includes the most negative code, whose magnitude is 2^(DATA_W-1).
- R5: The scaled value is floor(magnitude / 2^SHIFT). It saturates at 2^SCALE_W-1 when the quotient does not fit in SCALE_W bits.
- R6: The running sum is the total of the scaled values of the last 2^DEPTH_LOG2 accepted samples. Slots not yet written since reset count as zero.
- R7: `avg_out` equals floor(running sum / 2^DEPTH_LOG2), sampled while `avg_valid` is high.
- R8: A reset in the middle of a stream discards all earlier samples. After reset, the sum counts only samples accepted since that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; the block advances only when high |
| in_data | input | DATA_W | Signed two's-complement sample |
| avg_valid | output | 1 | One-cycle pulse per accepted sample, three edges later |
| avg_out | output | SCALE_W | Window mean of the scaled magnitudes |

## Verification
The bench builds the block with DATA_W=24, SHIFT=4, SCALE_W=16 and DEPTH_LOG2=4. This puts a 16-deep ring in place of the default 1024, so the pointer wraps and old values leave the window dozens of times within a short run. The narrow shift lets small inputs give nonzero scaled values. Because DATA_W-SHIFT exceeds SCALE_W, both the clipping of large magnitudes and the most-negative-code case occur. The same settings make the ramp-up after reset and a reset in the middle of a stream short enough to check sample by sample.

// File: rtl/mavg_pkg.sv
// Package: shared defaults for the magnitude moving averager.
// Assumes: consumers may override any value through module parameters.
package mavg_pkg;
    localparam int MAVG_DATA_W     = 44;
    localparam int MAVG_SHIFT      = 28;
    localparam int MAVG_SCALE_W    = 16;
    localparam int MAVG_DEPTH_LOG2 = 10;

    // Width that holds the sum of 2^depth_log2 values of scale_w bits.
    function automatic int sum_width(input int scale_w, input int depth_log2);
        return scale_w + depth_log2;
    endfunction
endpackage

// File: rtl/mavg_mag_scale.sv
// Module: mavg_mag_scale
// Takes the absolute value of a signed sample, shifts it right by SHIFT and
// clips the result to SCALE_W unsigned bits. Registers the result on valid.
// Assumes: the sample is two's complement; the most negative code is legal.
module mavg_mag_scale #(
    parameter int DATA_W  = 44,
    parameter int SHIFT   = 28,
    parameter int SCALE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [DATA_W-1:0]  in_data,
    output logic                      out_valid,
    output logic [SCALE_W-1:0]        out_scale
);
    localparam int MAG_W = DATA_W + 1;
    localparam int CMP_W = (MAG_W > SCALE_W) ? MAG_W : SCALE_W;
    localparam logic [CMP_W-1:0] SCALE_MAX = CMP_W'({SCALE_W{1'b1}});

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] shifted;
    logic [CMP_W-1:0] wide;
    logic [SCALE_W-1:0] clipped;

    // Absolute value in one extra bit, then shift and clip.
    always_comb begin
        ext     = {in_data[DATA_W-1], in_data};
        mag     = ext[MAG_W-1] ? (~ext + 1'b1) : ext;
        shifted = mag >> SHIFT;
        wide    = CMP_W'(shifted);
        clipped = (wide > SCALE_MAX) ? {SCALE_W{1'b1}} : SCALE_W'(wide);
    end

    // Capture the scaled value and pass the strobe on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_scale <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_scale <= clipped;
            end
        end
    end
endmodule

// File: rtl/mavg_window.sv
// Module: mavg_window
// Ring of 2^ADDR_W scaled values. On each write it reads the slot under the
// pointer (the value leaving the window) before overwriting it, then steps
// the pointer. Until the ring has wrapped once, the leaving value is zero.
// Assumes: storage is inferred memory without reset; a flag masks stale data.
module mavg_window #(
    parameter int SCALE_W = 16,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SCALE_W-1:0] wr_data,
    output logic               pair_valid,
    output logic [SCALE_W-1:0] enter_q,
    output logic [SCALE_W-1:0] leave_q,
    output logic [ADDR_W-1:0]  wr_ptr,
    output logic               primed
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [SCALE_W-1:0] ring [DEPTH];

    // Write the new value into the ring (storage carries no reset).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ring[wr_ptr] <= wr_data;
        end
    end

    // Read the leaving value, step the pointer and track the first wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            primed     <= 1'b0;
            pair_valid <= 1'b0;
            enter_q    <= '0;
            leave_q    <= '0;
        end else begin
            pair_valid <= wr_en;
            if (wr_en) begin
                enter_q <= wr_data;
                leave_q <= primed ? ring[wr_ptr] : '0;
                wr_ptr  <= wr_ptr + 1'b1;
                if (wr_ptr == LAST) begin
                    primed <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mavg_accum.sv
// Module: mavg_accum
// Running window sum: adds the entering value, removes the leaving one and
// presents the sum divided by the window depth.
// Assumes: leaving values match earlier entering values, so the sum stays
// within SCALE_W+ADDR_W bits and never goes negative.
module mavg_accum #(
    parameter int SCALE_W = 16,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [SCALE_W-1:0] enter_val,
    input  logic [SCALE_W-1:0] leave_val,
    output logic               avg_valid,
    output logic [SCALE_W-1:0] avg
);
    localparam int SUM_W = mavg_pkg::sum_width(SCALE_W, ADDR_W);

    logic [SUM_W-1:0] sum_q;

    // Update the sum with one add and one subtract per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q     <= '0;
            avg_valid <= 1'b0;
        end else begin
            avg_valid <= in_valid;
            if (in_valid) begin
                sum_q <= sum_q + SUM_W'(enter_val) - SUM_W'(leave_val);
            end
        end
    end

    // Divide by the window depth.
    assign avg = SCALE_W'(sum_q >> ADDR_W);
endmodule

// File: rtl/mag_avg_top.sv
// Module: mag_avg_top
// Magnitude moving averager: abs -> shift/clip -> ring window -> mean.
// Three register stages from an accepted sample to its average strobe.
// Assumes: synchronous active-low reset, held for at least one rising edge.
module mag_avg_top #(
    parameter int DATA_W     = mavg_pkg::MAVG_DATA_W,
    parameter int SHIFT      = mavg_pkg::MAVG_SHIFT,
    parameter int SCALE_W    = mavg_pkg::MAVG_SCALE_W,
    parameter int DEPTH_LOG2 = mavg_pkg::MAVG_DEPTH_LOG2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     avg_valid,
    output logic [SCALE_W-1:0]       avg_out
);
    logic                  s1_valid;
    logic [SCALE_W-1:0]    s1_scale;
    logic                  s2_valid;
    logic [SCALE_W-1:0]    s2_enter;
    logic [SCALE_W-1:0]    s2_leave;
    logic [DEPTH_LOG2-1:0] wr_ptr;
    logic                  primed;

    mavg_mag_scale #(
        .DATA_W (DATA_W),
        .SHIFT  (SHIFT),
        .SCALE_W(SCALE_W)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(s1_valid),
        .out_scale(s1_scale)
    );

    mavg_window #(
        .SCALE_W(SCALE_W),
        .ADDR_W (DEPTH_LOG2)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (s1_valid),
        .wr_data   (s1_scale),
        .pair_valid(s2_valid),
        .enter_q   (s2_enter),
        .leave_q   (s2_leave),
        .wr_ptr    (wr_ptr),
        .primed    (primed)
    );

    mavg_accum #(
        .SCALE_W(SCALE_W),
        .ADDR_W (DEPTH_LOG2)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s2_valid),
        .enter_val(s2_enter),
        .leave_val(s2_leave),
        .avg_valid(avg_valid),
        .avg      (avg_out)
    );
endmodule

// File: rtl/mag_avg_checker.sv
// Module: mag_avg_checker
// Timing and state properties of mag_avg_top, attached by bind below.
// Assumes: reset is low at the first rising edge.
module mag_avg_checker #(
    parameter int OUT_W  = 16,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              avg_valid,
    input logic [OUT_W-1:0]  avg_out,
    input logic              stage_valid,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              primed
);
    // R1: reset clears the outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!avg_valid && avg_out == '0));

    // R2: an accepted sample yields a strobe three edges later.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 avg_valid);

    // R3: no strobe without an accepted sample.
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !avg_valid);

    // R3: the average holds between strobes.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!avg_valid && $past(rst_n)) |-> $stable(avg_out));

    // R6: the ring pointer moves only on a write.
    p_ptr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_valid |=> $stable(wr_ptr));

    // R6: stored data counts only after a full wrap, at pointer zero.
    p_prime_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed) |-> (wr_ptr == '0));
endmodule

bind mag_avg_top mag_avg_checker #(
    .OUT_W (SCALE_W),
    .ADDR_W(DEPTH_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .avg_valid  (avg_valid),
    .avg_out    (avg_out),
    .stage_valid(s1_valid),
    .wr_ptr     (wr_ptr),
    .primed     (primed)
);

// File: tb/mag_avg_top_test.sv
// Bench for mag_avg_top: directed corners plus seeded random stimulus,
// compared each cycle against a reference window model.
module mag_avg_top_test;
    localparam int DW = 24;
    localparam int SH = 4;
    localparam int SW = 16;
    localparam int DL = 4;
    localparam int DEPTH = 1 << DL;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [DW-1:0] in_data;
    logic avg_valid;
    logic [SW-1:0] avg_out;

    int checks = 0;
    int errors = 0;

    int  win [DEPTH];
    int  wp;
    longint sum;
    logic  pend_v [1:3];
    int    pend_a [1:3];
    string pend_t [1:3];
    int    last_avg;

    always #10 clk = ~clk;

    mag_avg_top #(.DATA_W(DW), .SHIFT(SH), .SCALE_W(SW), .DEPTH_LOG2(DL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .avg_valid(avg_valid), .avg_out(avg_out)
    );

    // R4/R5 reference: absolute value, shift, clip.
    function automatic int scale_of(input logic signed [DW-1:0] x);
        longint m = (x < 0) ? -longint'(x) : longint'(x);
        longint s = m >>> SH;
        return (s > 65535) ? 65535 : int'(s);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) win[i] = 0;
        wp = 0; sum = 0; last_avg = 0;
        for (int i = 1; i <= 3; i++) begin pend_v[i] = 1'b0; pend_a[i] = 0; pend_t[i] = ""; end
    endtask

    // One cycle: check what is due now, then drive the next input.
    task automatic step(input logic v, input logic signed [DW-1:0] d, input string tag);
        @(negedge clk);
        check("R2 strobe", int'(avg_valid), int'(pend_v[3]));
        if (pend_v[3]) begin
            check(pend_t[3], int'(avg_out), pend_a[3]);
            last_avg = pend_a[3];
        end else begin
            check("R3 hold", int'(avg_out), last_avg);
        end
        pend_v[3] = pend_v[2]; pend_a[3] = pend_a[2]; pend_t[3] = pend_t[2];
        pend_v[2] = pend_v[1]; pend_a[2] = pend_a[1]; pend_t[2] = pend_t[1];
        in_valid = v;
        in_data  = d;
        pend_v[1] = v;
        if (v) begin
            int s = scale_of(d);
            sum = sum + s - win[wp];
            win[wp] = s;
            wp = (wp + 1) % DEPTH;
            pend_a[1] = int'(sum >>> DL);
            pend_t[1] = tag;
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (2) @(negedge clk);
        check({tag, " valid"}, int'(avg_valid), 0);
        check({tag, " avg"}, int'(avg_out), 0);
        model_clear();
        rst_n = 1'b1;
    endtask

    function automatic logic signed [DW-1:0] rnd_data();
        int sel = $urandom % 4;
        case (sel)
            0: return DW'($urandom);
            1: return DW'(int'($urandom % 1024) - 512);
            2: return ($urandom % 2) ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
            default: return '0;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        model_clear();
        repeat (3) @(negedge clk);
        check("R1 valid", int'(avg_valid), 0);
        check("R1 avg", int'(avg_out), 0);
        rst_n = 1'b1;

        // R4, R6: negative ramp from an empty window to mean 100.
        for (int i = 0; i < DEPTH; i++) step(1'b1, -DW'(100 << SH), "R6 ramp");
        step(1'b0, '0, "R3");
        step(1'b0, 24'sd777, "R3");
        // R4, R5: positive magnitude with remainder floors to the same scale.
        for (int i = 0; i < DEPTH; i++) step(1'b1, DW'((100 << SH) + 15), "R5 floor");
        // R4, R5: most negative code and positive full scale both clip.
        for (int i = 0; i < DEPTH; i++) step(1'b1, {1'b1, {(DW-1){1'b0}}}, "R4 most negative");
        for (int i = 0; i < DEPTH; i++) step(1'b1, {1'b0, {(DW-1){1'b1}}}, "R5 saturate");
        // R6, R7: zeros push the large values out.
        for (int i = 0; i < DEPTH; i++) step(1'b1, '0, "R7 drain");

        for (int i = 0; i < 600; i++)
            step(($urandom % 10) < 7, rnd_data(), "R6 random");

        // R8: reset in mid stream forgets earlier samples.
        do_reset("R8 reset");
        step(1'b1, DW'(320 << SH), "R8 fresh window");
        for (int i = 0; i < 300; i++)
            step(($urandom % 10) < 7, rnd_data(), "R7 random");
        for (int i = 0; i < 4; i++) step(1'b0, '0, "R3 tail");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule